// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This block is a small processor whose arithmetic instructions name no registers at all. Every ALU instruction takes its two operands from the top of an on-chip expression stack and leaves one result there. Constants enter the stack only through a push-immediate instruction. Data moves between the stack and a small internal data memory through load and store instructions. Control flow uses an absolute jump, a pop-and-test branch, and call/return. Return addresses are kept on a second, separate stack that holds nothing else.

Instructions are fetched from an external synchronous instruction memory, which returns the word one cycle after the address is presented. An instruction without an operand takes two cycles. An instruction followed by an operand word takes three cycles. A HALT instruction, or any stack fault, stops the core. The top-of-stack value, the current stack depth and the stop and fault flags stay visible on the output ports until the next reset.

Top module: `stk_core`

## Requirements
- R1: While reset is held (`rst_n` low), `depth` is 0, `tos` is 0, `halted` and `fault` are 0, and `imem_addr` is 0. Reset also clears a fault left by an earlier run.
- R2: The binary ALU operations are ADD 0x10, SUB 0x11, MUL 0x12 (low 16 bits of the product), AND 0x13, OR 0x14 and XOR 0x15. Each one removes the top two entries and leaves a single result, so the depth drops by one. The entry second from the top is the left operand, so pushing A then B and applying SUB gives A−B.
- R3: The opcode sits in bits [5:0] of an instruction word, and bits [15:6] are ignored. PUSH 0x02 is followed by one operand word, and the full 16-bit operand is pushed.
- R4: DUP 0x18 copies the top entry. DROP 0x19 discards the top entry. SWAP 0x1A exchanges the top two entries without changing the depth.
- R5: LDA 0x03 and STA 0x04 take the data-memory word address from the low 4 bits of their operand word. LDA pushes the memory word. STA pops the top entry into memory.
- R6: LDS 0x05 pops an address and pushes the memory word at that address. STS 0x06 pops an address (the top entry) and then a value (the entry below it), and writes the value to memory. Both use the low 4 bits of the address.
- R7: JMP 0x07 jumps to its operand word. JZ 0x08 pops the top entry and jumps to its operand word only when the popped value is zero.
- R8: CALL 0x09 pushes the address after its operand word onto a separate 8-entry return stack and jumps to its operand. RET 0x0A pops that address into the program counter. The expression stack is not touched by either.
- R9: The expression stack holds 16 entries. An instruction that would push past 16 entries, or that needs more entries than are present, sets a sticky `fault`, stops the core, and leaves the stack unchanged.
- R10: A CALL when the return stack already holds 8 addresses, or a RET when it is empty, sets `fault` and stops the core.
- R11: HALT 0x01 stops fetching. After a HALT, `imem_addr`, `tos` and `depth` hold their values, and no later instruction takes effect.
- R12: Opcodes not listed in R2–R11, and NOP 0x00, change nothing and fetch continues with the next word.
- R13: The sequence PUSH A, PUSH B, PUSH C, SUB, MUL, PUSH D, PUSH E, ADD, ADD leaves A*(B−C)+(D+E), taken modulo 2^16, as the only stack entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 8 | Instruction memory word address |
| imem_rdata | input | 16 | Instruction memory word, valid one cycle after its address |
| tos | output | 16 | Current top-of-stack value, 0 when the stack is empty |
| depth | output | 5 | Number of entries on the expression stack |
| halted | output | 1 | Core has stopped (HALT or fault) |
| fault | output | 1 | Sticky stack overflow/underflow flag |

## Verification
A wrong stack pointer or a misplaced write shows at `depth` and `tos` as soon as the instruction that caused it completes. For programs that end in HALT, the bench reads these once the core has stopped, so an error is seen within the run of one short program. A swapped operand order appears right away as the sign of a SUB result. A wrong return address or branch target causes a later push to be skipped or repeated, and this shows in the final `tos`/`depth` pair. A missed depth check shows as `fault` staying low, or as a wrapped `depth`, on the first instruction that goes past the stack limits.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_ARG    = 2'd2,
        ST_STOP   = 2'd3
    } phase_e;

    localparam logic [5:0] OP_NOP  = 6'h00;
    localparam logic [5:0] OP_HALT = 6'h01;
    localparam logic [5:0] OP_PUSH = 6'h02;
    localparam logic [5:0] OP_LDA  = 6'h03;
    localparam logic [5:0] OP_STA  = 6'h04;
    localparam logic [5:0] OP_LDS  = 6'h05;
    localparam logic [5:0] OP_STS  = 6'h06;
    localparam logic [5:0] OP_JMP  = 6'h07;
    localparam logic [5:0] OP_JZ   = 6'h08;
    localparam logic [5:0] OP_CALL = 6'h09;
    localparam logic [5:0] OP_RET  = 6'h0A;
    localparam logic [5:0] OP_ADD  = 6'h10;
    localparam logic [5:0] OP_SUB  = 6'h11;
    localparam logic [5:0] OP_MUL  = 6'h12;
    localparam logic [5:0] OP_AND  = 6'h13;
    localparam logic [5:0] OP_OR   = 6'h14;
    localparam logic [5:0] OP_XOR  = 6'h15;
    localparam logic [5:0] OP_DUP  = 6'h18;
    localparam logic [5:0] OP_DROP = 6'h19;
    localparam logic [5:0] OP_SWAP = 6'h1A;

    // Per-opcode stack footprint: entries required, entries removed, entry added.
    typedef struct packed {
        logic       has_arg;
        logic [1:0] need;
        logic [1:0] shrink;
        logic       grow;
        logic       is_alu;
    } opinfo_t;

endpackage

// File: rtl/stk_decode.sv
`timescale 1ns/1ps
module stk_decode
    import stk_pkg::*;
(
    input  logic [5:0] opc,
    output opinfo_t    info
);

    always_comb begin
        info = '0;
        case (opc)
            OP_PUSH: begin
                info.has_arg = 1'b1;
                info.grow    = 1'b1;
            end
            OP_LDA: begin
                info.has_arg = 1'b1;
                info.grow    = 1'b1;
            end
            OP_STA: begin
                info.has_arg = 1'b1;
                info.need    = 2'd1;
                info.shrink  = 2'd1;
            end
            OP_LDS: begin
                info.need    = 2'd1;
                info.shrink  = 2'd1;
                info.grow    = 1'b1;
            end
            OP_STS: begin
                info.need    = 2'd2;
                info.shrink  = 2'd2;
            end
            OP_JMP, OP_CALL: begin
                info.has_arg = 1'b1;
            end
            OP_JZ: begin
                info.has_arg = 1'b1;
                info.need    = 2'd1;
                info.shrink  = 2'd1;
            end
            OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR: begin
                info.need    = 2'd2;
                info.shrink  = 2'd2;
                info.grow    = 1'b1;
                info.is_alu  = 1'b1;
            end
            OP_DUP: begin
                info.need    = 2'd1;
                info.grow    = 1'b1;
            end
            OP_DROP: begin
                info.need    = 2'd1;
                info.shrink  = 2'd1;
            end
            OP_SWAP: begin
                info.need    = 2'd2;
            end
            default: info = '0;
        endcase
    end

endmodule

// File: rtl/stk_alu.sv
`timescale 1ns/1ps
module stk_alu
    import stk_pkg::*;
#(
    parameter int DW = 16
)(
    input  logic [5:0]    opc,
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    output logic [DW-1:0] res
);

    logic [2*DW-1:0] prod;

    always_comb begin
        prod = {{DW{1'b0}}, lhs} * {{DW{1'b0}}, rhs};
        case (opc)
            OP_ADD:  res = lhs + rhs;
            OP_SUB:  res = lhs - rhs;
            OP_MUL:  res = prod[DW-1:0];
            OP_AND:  res = lhs & rhs;
            OP_OR:   res = lhs | rhs;
            OP_XOR:  res = lhs ^ rhs;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/stk_dmem.sv
`timescale 1ns/1ps
module stk_dmem #(
    parameter int DW  = 16,
    parameter int DAW = 4,
    localparam int DEPTH = 1 << DAW
)(
    input  logic           clk,
    input  logic           we,
    input  logic [DAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [DAW-1:0] raddr,
    output logic [DW-1:0]  rdata
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/stk_core.sv
`timescale 1ns/1ps
module stk_core
    import stk_pkg::*;
#(
    parameter int DW       = 16,
    parameter int ES_DEPTH = 16,
    parameter int RS_DEPTH = 8,
    parameter int PAW      = 8,
    parameter int DAW      = 4,
    localparam int SPW     = $clog2(ES_DEPTH + 1)
)(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PAW-1:0]  imem_addr,
    input  logic [DW-1:0]   imem_rdata,
    output logic [DW-1:0]   tos,
    output logic [SPW-1:0]  depth,
    output logic            halted,
    output logic            fault
);

    localparam int RPW = $clog2(RS_DEPTH + 1);
    localparam int EIW = $clog2(ES_DEPTH);
    localparam int RIW = $clog2(RS_DEPTH);

    typedef struct packed {
        phase_e                        ph;
        logic [PAW-1:0]                pc;
        logic [5:0]                    opc;
        logic [SPW-1:0]                sp;
        logic [RPW-1:0]                rp;
        logic                          flt;
        logic [ES_DEPTH-1:0][DW-1:0]   es;
        logic [RS_DEPTH-1:0][PAW-1:0]  rs;
    } core_t;

    core_t c_q, c_d;

    logic [5:0]     cur_op;
    opinfo_t        info;
    logic           exec;
    logic [DW-1:0]  arg;
    logic [EIW-1:0] i_top, i_nxt, i_base;
    logic [SPW-1:0] base;
    logic [DW-1:0]  t_val, n_val;
    logic [DW-1:0]  alu_res;
    logic [DW-1:0]  push_val;
    logic [PAW-1:0] pc_seq;
    logic           es_under, es_over, rs_over, rs_under, bad;

    logic           dm_we;
    logic [DAW-1:0] dm_waddr, dm_raddr;
    logic [DW-1:0]  dm_wdata, dm_rdata;

    // ---------------- operand and decode view ----------------
    assign cur_op = (c_q.ph == ST_ARG) ? c_q.opc : imem_rdata[5:0];
    assign arg    = imem_rdata;
    assign exec   = ((c_q.ph == ST_DECODE) && !info.has_arg) || (c_q.ph == ST_ARG);
    assign pc_seq = (c_q.ph == ST_ARG) ? (c_q.pc + PAW'(2)) : (c_q.pc + PAW'(1));

    assign i_top  = EIW'(c_q.sp - SPW'(1));
    assign i_nxt  = EIW'(c_q.sp - SPW'(2));
    assign base   = c_q.sp - SPW'(info.shrink);
    assign i_base = EIW'(base);
    assign t_val  = c_q.es[i_top];
    assign n_val  = c_q.es[i_nxt];

    stk_decode u_dec (
        .opc  (cur_op),
        .info (info)
    );

    stk_alu #(.DW(DW)) u_alu (
        .opc (cur_op),
        .lhs (n_val),
        .rhs (t_val),
        .res (alu_res)
    );

    assign dm_raddr = (cur_op == OP_LDS) ? t_val[DAW-1:0] : arg[DAW-1:0];

    stk_dmem #(.DW(DW), .DAW(DAW)) u_mem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (dm_raddr),
        .rdata (dm_rdata)
    );

    // ---------------- limit checks ----------------
    assign es_under = c_q.sp < SPW'(info.need);
    assign es_over  = (c_q.sp == SPW'(ES_DEPTH)) && info.grow && (info.shrink == 2'd0);
    assign rs_over  = (cur_op == OP_CALL) && (c_q.rp == RPW'(RS_DEPTH));
    assign rs_under = (cur_op == OP_RET) && (c_q.rp == RPW'(0));
    assign bad      = exec && (es_under || es_over || rs_over || rs_under);

    always_comb begin
        case (cur_op)
            OP_PUSH:        push_val = arg;
            OP_LDA, OP_LDS: push_val = dm_rdata;
            OP_DUP:         push_val = t_val;
            default:        push_val = alu_res;
        endcase
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        c_d      = c_q;
        dm_we    = 1'b0;
        dm_waddr = arg[DAW-1:0];
        dm_wdata = t_val;

        case (c_q.ph)
            ST_FETCH:  c_d.ph = ST_DECODE;
            ST_DECODE: begin
                if (info.has_arg) begin
                    c_d.opc = cur_op;
                    c_d.ph  = ST_ARG;
                end
            end
            default: ;
        endcase

        if (exec) begin
            if (bad) begin
                c_d.flt = 1'b1;
                c_d.ph  = ST_STOP;
            end else begin
                c_d.ph = ST_FETCH;
                c_d.pc = pc_seq;
                case (cur_op)
                    OP_HALT: begin
                        c_d.ph = ST_STOP;
                        c_d.pc = c_q.pc;
                    end
                    OP_STA: begin
                        dm_we    = 1'b1;
                        dm_waddr = arg[DAW-1:0];
                        dm_wdata = t_val;
                    end
                    OP_STS: begin
                        dm_we    = 1'b1;
                        dm_waddr = t_val[DAW-1:0];
                        dm_wdata = n_val;
                    end
                    OP_JMP: c_d.pc = arg[PAW-1:0];
                    OP_JZ: begin
                        if (t_val == '0) begin
                            c_d.pc = arg[PAW-1:0];
                        end
                    end
                    OP_CALL: begin
                        c_d.rs[RIW'(c_q.rp)] = pc_seq;
                        c_d.rp               = c_q.rp + RPW'(1);
                        c_d.pc               = arg[PAW-1:0];
                    end
                    OP_RET: begin
                        c_d.pc = c_q.rs[RIW'(c_q.rp - RPW'(1))];
                        c_d.rp = c_q.rp - RPW'(1);
                    end
                    OP_SWAP: begin
                        c_d.es[i_top] = n_val;
                        c_d.es[i_nxt] = t_val;
                    end
                    default: ;
                endcase
                if (info.grow) begin
                    c_d.es[i_base] = push_val;
                end
                c_d.sp = base + SPW'(info.grow);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    // ---------------- outputs ----------------
    assign imem_addr = (c_q.ph == ST_DECODE) ? (c_q.pc + PAW'(1)) : c_q.pc;
    assign tos       = (c_q.sp == '0) ? '0 : t_val;
    assign depth     = c_q.sp;
    assign halted    = (c_q.ph == ST_STOP);
    assign fault     = c_q.flt;

    // ---------------- assertions ----------------
    // R9
    es_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.sp <= SPW'(ES_DEPTH));

    // R10
    rs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.rp <= RPW'(RS_DEPTH));

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (fault && halted));

    // R11
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(imem_addr) && $stable(depth) && $stable(tos)));

    // R2
    alu_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && info.is_alu && !bad) |=> (depth == $past(depth) - SPW'(1)));

    // R3
    push_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (cur_op == OP_PUSH) && !bad) |=> (tos == $past(imem_rdata)));

endmodule

// File: tb/sim_stk_core.sv
`timescale 1ns/1ps
module sim_stk_core;

    localparam logic [15:0] W_NOP  = 16'h0000;
    localparam logic [15:0] W_HALT = 16'h0001;
    localparam logic [15:0] W_PUSH = 16'h0002;
    localparam logic [15:0] W_LDA  = 16'h0003;
    localparam logic [15:0] W_STA  = 16'h0004;
    localparam logic [15:0] W_LDS  = 16'h0005;
    localparam logic [15:0] W_STS  = 16'h0006;
    localparam logic [15:0] W_JMP  = 16'h0007;
    localparam logic [15:0] W_JZ   = 16'h0008;
    localparam logic [15:0] W_CALL = 16'h0009;
    localparam logic [15:0] W_RET  = 16'h000A;
    localparam logic [15:0] W_ADD  = 16'h0010;
    localparam logic [15:0] W_SUB  = 16'h0011;
    localparam logic [15:0] W_MUL  = 16'h0012;
    localparam logic [15:0] W_DUP  = 16'h0018;
    localparam logic [15:0] W_DROP = 16'h0019;
    localparam logic [15:0] W_SWAP = 16'h001A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  imem_addr;
    logic [15:0] imem_rdata;
    logic [15:0] tos;
    logic [4:0]  depth;
    logic        halted;
    logic        fault;

    logic [15:0] prog [256];
    int          wp;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    stk_core u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .tos        (tos),
        .depth      (depth),
        .halted     (halted),
        .fault      (fault)
    );

    always_ff @(posedge clk) imem_rdata <= prog[imem_addr];

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = W_HALT;
        wp = 0;
    endtask

    task automatic emit(input logic [15:0] w);
        prog[wp] = w;
        wp++;
    endtask

    task automatic emit2(input logic [15:0] op, input logic [15:0] v);
        emit(op);
        emit(v);
    endtask

    task automatic run_prog();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 3000 && !halted; c++) @(negedge clk);
    endtask

    function automatic logic [15:0] ref_alu(input int k, input logic [15:0] a, input logic [15:0] b);
        logic [15:0] r;
        case (k)
            0: r = a + b;
            1: r = a - b;
            2: r = a * b;
            3: r = a & b;
            4: r = a | b;
            default: r = a ^ b;
        endcase
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] vals [8];
        logic [15:0] ev [3];
        vals = '{16'h0000, 16'h0001, 16'h0002, 16'h0007, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
        ev   = '{16'h0003, 16'hFFFE, 16'h0100};

        // R1: reset state, also after a faulted run
        clear_prog();
        emit(W_DROP);
        run_prog();
        chk("R1 pre: fault after bad run", fault, 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 depth in reset", depth, 0);
        chk("R1 tos in reset", tos, 0);
        chk("R1 halted in reset", halted, 0);
        chk("R1 fault cleared by reset", fault, 0);
        chk("R1 imem_addr in reset", imem_addr, 0);

        // R2: ALU sweep over operand pairs
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    clear_prog();
                    emit2(W_PUSH, vals[i]);
                    emit2(W_PUSH, vals[j]);
                    emit(W_ADD + 16'(k));
                    run_prog();
                    chk($sformatf("R2 op%0d %h,%h", k, vals[i], vals[j]), tos, ref_alu(k, vals[i], vals[j]));
                    chk("R2 depth after binary op", depth, 1);
                end
            end
        end

        // R3: push-immediate and ignored upper bits of the opcode word
        clear_prog();
        emit2(W_PUSH | 16'hFFC0, 16'hBEEF);
        run_prog();
        chk("R3 push with high bits set", tos, 16'hBEEF);
        chk("R3 depth", depth, 1);

        // R4: DUP, DROP, SWAP
        clear_prog();
        emit2(W_PUSH, 16'h0123); emit(W_DUP); emit(W_ADD);
        run_prog();
        chk("R4 dup+add", tos, 16'h0246);
        chk("R4 dup depth", depth, 1);
        clear_prog();
        emit2(W_PUSH, 16'h0011); emit2(W_PUSH, 16'h0022); emit(W_SWAP);
        run_prog();
        chk("R4 swap top", tos, 16'h0011);
        chk("R4 swap depth", depth, 2);
        clear_prog();
        emit2(W_PUSH, 16'h0011); emit2(W_PUSH, 16'h0022); emit(W_SWAP); emit(W_SUB);
        run_prog();
        chk("R4 swap then sub", tos, 16'h0011);
        clear_prog();
        emit2(W_PUSH, 16'h0011); emit2(W_PUSH, 16'h0022); emit(W_DROP);
        run_prog();
        chk("R4 drop top", tos, 16'h0011);
        chk("R4 drop depth", depth, 1);

        // R5: addressed store then load, every cell
        for (int j = 0; j < 16; j++) begin
            clear_prog();
            for (int k = 0; k < 16; k++) begin
                emit2(W_PUSH, 16'(k) * 16'h0101 + 16'h0A00);
                emit2(W_STA, 16'(k) | 16'hFF00);
            end
            emit2(W_LDA, 16'(j));
            run_prog();
            chk($sformatf("R5 load cell %0d", j), tos, 16'(j) * 16'h0101 + 16'h0A00);
            chk("R5 depth after stores and load", depth, 1);
        end

        // R6: stack-addressed store and load
        clear_prog();
        emit2(W_PUSH, 16'h5A5A); emit2(W_PUSH, 16'h0035); emit(W_STS);
        emit2(W_PUSH, 16'h0005); emit(W_LDS);
        run_prog();
        chk("R6 lds value", tos, 16'h5A5A);
        chk("R6 depth", depth, 1);
        clear_prog();
        emit2(W_LDA, 16'h0005);
        run_prog();
        chk("R6 sts cell seen by lda", tos, 16'h5A5A);

        // R7: jumps
        clear_prog();
        emit2(W_JMP, 16'd4); emit2(W_PUSH, 16'd1); emit2(W_PUSH, 16'd9);
        run_prog();
        chk("R7 jmp skips push", tos, 9);
        chk("R7 jmp depth", depth, 1);
        clear_prog();
        emit2(W_PUSH, 16'd5); emit2(W_PUSH, 16'd0); emit2(W_JZ, 16'd8); emit2(W_PUSH, 16'd7);
        run_prog();
        chk("R7 jz taken tos", tos, 5);
        chk("R7 jz taken depth", depth, 1);
        clear_prog();
        emit2(W_PUSH, 16'd5); emit2(W_PUSH, 16'd3); emit2(W_JZ, 16'd8); emit2(W_PUSH, 16'd7);
        run_prog();
        chk("R7 jz not taken tos", tos, 7);
        chk("R7 jz not taken depth", depth, 2);

        // R8: call/return
        clear_prog();
        emit2(W_PUSH, 16'd2); emit2(W_CALL, 16'd10); emit2(W_PUSH, 16'd3); emit(W_ADD); emit(W_HALT);
        prog[10] = W_DUP; prog[11] = W_ADD; prog[12] = W_RET;
        run_prog();
        chk("R8 call/ret result", tos, 7);
        chk("R8 call/ret depth", depth, 1);
        chk("R8 no fault", fault, 0);

        // R8 / R10: nesting 8 deep works, 9 deep faults
        for (int lv = 8; lv <= 9; lv++) begin
            clear_prog();
            emit2(W_CALL, 16'd20);
            for (int i = 0; i < lv - 1; i++) begin
                prog[20 + 3*i]     = W_CALL;
                prog[20 + 3*i + 1] = 16'(20 + 3*(i + 1));
                prog[20 + 3*i + 2] = W_RET;
            end
            prog[20 + 3*(lv-1)]     = W_PUSH;
            prog[20 + 3*(lv-1) + 1] = 16'h0055;
            prog[20 + 3*(lv-1) + 2] = W_RET;
            run_prog();
            if (lv == 8) begin
                chk("R8 nest 8 tos", tos, 16'h0055);
                chk("R8 nest 8 fault", fault, 0);
            end else begin
                chk("R10 nest 9 fault", fault, 1);
                chk("R10 nest 9 halted", halted, 1);
                chk("R10 nest 9 depth", depth, 0);
            end
        end
        clear_prog();
        emit2(W_PUSH, 16'd4); emit(W_RET);
        run_prog();
        chk("R10 ret on empty fault", fault, 1);
        chk("R10 ret on empty keeps stack", tos, 4);

        // R9: fill sweep up to and past the limit
        for (int n = 1; n <= 17; n++) begin
            clear_prog();
            for (int i = 1; i <= n; i++) emit2(W_PUSH, 16'(i) * 16'h0111);
            run_prog();
            if (n <= 16) begin
                chk($sformatf("R9 fill %0d depth", n), depth, n);
                chk("R9 fill tos", tos, 16'(n) * 16'h0111);
                chk("R9 fill no fault", fault, 0);
            end else begin
                chk("R9 overflow fault", fault, 1);
                chk("R9 overflow depth kept", depth, 16);
                chk("R9 overflow tos kept", tos, 16'd16 * 16'h0111);
            end
        end
        clear_prog();
        for (int i = 0; i < 16; i++) emit2(W_PUSH, 16'(i));
        emit(W_DUP);
        run_prog();
        chk("R9 dup overflow fault", fault, 1);
        chk("R9 dup overflow depth", depth, 16);
        clear_prog();
        emit2(W_PUSH, 16'h0077); emit(W_ADD);
        run_prog();
        chk("R9 add underflow fault", fault, 1);
        chk("R9 add underflow depth", depth, 1);
        chk("R9 add underflow tos", tos, 16'h0077);
        clear_prog();
        emit2(W_PUSH, 16'h0078); emit(W_SWAP);
        run_prog();
        chk("R9 swap underflow fault", fault, 1);
        chk("R9 swap underflow tos", tos, 16'h0078);

        // R11: halt freezes outputs
        clear_prog();
        emit2(W_PUSH, 16'd4); emit(W_HALT); emit2(W_PUSH, 16'd6);
        run_prog();
        begin
            logic [7:0] a0;
            a0 = imem_addr;
            repeat (10) @(negedge clk);
            chk("R11 tos held", tos, 4);
            chk("R11 depth held", depth, 1);
            chk("R11 fetch address held", imem_addr, a0);
            chk("R11 halted", halted, 1);
            chk("R11 no fault", fault, 0);
        end

        // R12: undefined opcodes and NOP are no-ops
        clear_prog();
        emit2(W_PUSH, 16'd3); emit2(W_PUSH, 16'd4);
        emit(16'h003F); emit(16'h000B); emit(16'h00C0); emit(W_NOP); emit(16'h001F);
        emit(16'hFF11);
        run_prog();
        chk("R12 undefined no-op tos", tos, 16'hFFFF);
        chk("R12 undefined no-op depth", depth, 1);
        chk("R12 no fault", fault, 0);

        // R13: worked postfix expression sweep
        for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
        for (int d = 0; d < 3; d++)
        for (int e = 0; e < 3; e++) begin
            logic [15:0] exp_v;
            clear_prog();
            emit2(W_PUSH, ev[a]); emit2(W_PUSH, ev[b]); emit2(W_PUSH, ev[c]);
            emit(W_SUB); emit(W_MUL);
            emit2(W_PUSH, ev[d]); emit2(W_PUSH, ev[e]);
            emit(W_ADD); emit(W_ADD);
            run_prog();
            exp_v = ev[a] * (ev[b] - ev[c]) + (ev[d] + ev[e]);
            chk("R13 expression value", tos, exp_v);
            chk("R13 sole entry", depth, 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule